// File: doc/BRIEF.md
# Register Alias Table Renamer

This block maps the logical integer registers of up to three micro-ops per cycle onto physical tags held in the reorder buffer. For each of eight logical registers it keeps a 6-bit reorder-buffer index and a committed flag. When the flag is set, the current value of that register is in the retirement register file and not in the reorder buffer. Every valid micro-op in the group reads two sources and writes one destination. The allocator supplies a fresh physical tag for each destination.

Source lookups are combinational in the cycle a group is presented. When a micro-op reads a register written by an older micro-op of the same group, the lookup takes that older micro-op's destination tag in place of the table contents. At the next clock edge the table records the group's destinations. Retirement notifications mark an entry as committed while the entry still points at the retiring tag. A flush marks every entry committed in one cycle, which is how the block recovers from a misprediction.

Top module: `rat_renamer`

## Requirements
- R1: After reset every entry has its committed flag at 1 and a tag of 0, so any source read reports tag 0 with the committed flag at 1.
- R2: A valid slot's source with no writer among the older valid slots of its group returns the stored tag and committed flag of that logical register, in the same cycle.
- R3: A source of slot s that matches the destination of a valid older slot j < s returns that slot's destination tag with the committed flag at 0. When several older slots match, the nearest older one (largest j) is used.
- R4: A slot whose valid bit is 0 neither overrides a younger slot's lookup nor updates the table.
- R5: When flush is low, each logical register written by the group maps, from the next cycle, to the tag of the youngest valid slot that writes it, with the committed flag at 0.
- R6: A retirement with valid set and a tag equal to an entry's stored tag sets that entry's committed flag in the next cycle and leaves the tag unchanged. A retirement whose tag matches no entry changes nothing.
- R7: When a rename and a matching retirement reach the same entry in one cycle, the rename wins: the new tag is stored and the committed flag is 0.
- R8: A flush sets every committed flag in the next cycle and leaves every tag unchanged. Renames presented in the flush cycle update nothing, but their lookups in that cycle still follow R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| uop_vld_i | input | 3 | Valid bit per slot; slot 0 is oldest |
| src_a_i | input | 9 | First source logical register per slot, 3 bits each |
| src_b_i | input | 9 | Second source logical register per slot, 3 bits each |
| dst_i | input | 9 | Destination logical register per slot, 3 bits each |
| dst_tag_i | input | 18 | Allocated physical tag per slot, 6 bits each |
| ret_vld_i | input | 3 | Retirement valid per retirement lane |
| ret_tag_i | input | 18 | Retiring physical tag per lane, 6 bits each |
| flush_i | input | 1 | Revert all mappings to the retirement register file |
| src_a_tag_o | output | 18 | Physical tag for first source per slot |
| src_a_rrf_o | output | 3 | Committed flag for first source per slot |
| src_b_tag_o | output | 18 | Physical tag for second source per slot |
| src_b_rrf_o | output | 3 | Committed flag for second source per slot |

## Verification
The hardest situation to reach from the ports is a retirement that hits an entry which is being renamed in the same cycle. A retirement tag drawn at random almost never equals a live mapping. The random traffic therefore takes half of its retirement tags from the bench's own current map, so matches with live entries are frequent, and a directed step builds the exact rename-against-retire collision. Chains of three same-register writers in one group are also constructed on purpose, because uniform register choice makes them rare.

// File: rtl/rat_pkg.sv
package rat_pkg;
  parameter int unsigned NUM_LREG = 8;
  parameter int unsigned LREG_W   = $clog2(NUM_LREG);
  parameter int unsigned TAG_W    = 6;
  parameter int unsigned GRP_W    = 3;
  parameter int unsigned RET_W    = 3;

  typedef logic [LREG_W-1:0] lreg_t;
  typedef logic [TAG_W-1:0]  ptag_t;
endpackage

// File: rtl/rat_table.sv
module rat_table
  import rat_pkg::*;
#(
  parameter int unsigned N_REG = NUM_LREG,
  parameter int unsigned N_GRP = GRP_W,
  parameter int unsigned N_RET = RET_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_GRP-1:0]          wr_vld_i,
  input  logic [N_GRP*LREG_W-1:0]   wr_reg_i,
  input  logic [N_GRP*TAG_W-1:0]    wr_tag_i,
  input  logic [N_RET-1:0]          ret_vld_i,
  input  logic [N_RET*TAG_W-1:0]    ret_tag_i,
  input  logic                      flush_i,
  output logic [N_REG*TAG_W-1:0]    map_tag_o,
  output logic [N_REG-1:0]          map_rrf_o
);
  ptag_t             tag_q [N_REG];
  logic [N_REG-1:0]  rrf_q;
  logic [N_REG-1:0]  wr_hit, ret_hit;
  ptag_t             wr_new [N_REG];

  // ascending slot scan: youngest writer is the last assignment
  always_comb begin
    for (int r = 0; r < int'(N_REG); r++) begin
      wr_hit[r]  = 1'b0;
      wr_new[r]  = tag_q[r];
      ret_hit[r] = 1'b0;
      for (int s = 0; s < int'(N_GRP); s++) begin
        if (wr_vld_i[s] && wr_reg_i[s*LREG_W +: LREG_W] == lreg_t'(r)) begin
          wr_hit[r] = 1'b1;
          wr_new[r] = wr_tag_i[s*TAG_W +: TAG_W];
        end
      end
      for (int k = 0; k < int'(N_RET); k++) begin
        if (ret_vld_i[k] && ret_tag_i[k*TAG_W +: TAG_W] == tag_q[r]) ret_hit[r] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < int'(N_REG); r++) tag_q[r] <= '0;
      rrf_q <= '1;
    end else begin
      for (int r = 0; r < int'(N_REG); r++) begin
        if (flush_i) begin
          rrf_q[r] <= 1'b1;
        end else if (wr_hit[r]) begin
          tag_q[r] <= wr_new[r];
          rrf_q[r] <= 1'b0;
        end else if (ret_hit[r]) begin
          rrf_q[r] <= 1'b1;
        end
      end
    end
  end

  for (genvar r = 0; r < N_REG; r++) begin : g_flat
    assign map_tag_o[r*TAG_W +: TAG_W] = tag_q[r];
  end
  assign map_rrf_o = rrf_q;
endmodule

// File: rtl/rat_src_lookup.sv
module rat_src_lookup
  import rat_pkg::*;
#(
  parameter int unsigned N_REG = NUM_LREG,
  parameter int unsigned N_GRP = GRP_W,
  parameter int unsigned SLOT  = 0
) (
  input  lreg_t                     src_i,
  input  logic [N_REG*TAG_W-1:0]    map_tag_i,
  input  logic [N_REG-1:0]          map_rrf_i,
  input  logic [N_GRP-1:0]          grp_vld_i,
  input  logic [N_GRP*LREG_W-1:0]   grp_dst_i,
  input  logic [N_GRP*TAG_W-1:0]    grp_tag_i,
  output ptag_t                     tag_o,
  output logic                      rrf_o
);
  // older in-group writers override the table; nearest older wins
  always_comb begin
    tag_o = map_tag_i[int'(src_i)*TAG_W +: TAG_W];
    rrf_o = map_rrf_i[src_i];
    for (int j = 0; j < int'(SLOT); j++) begin
      if (grp_vld_i[j] && grp_dst_i[j*LREG_W +: LREG_W] == src_i) begin
        tag_o = grp_tag_i[j*TAG_W +: TAG_W];
        rrf_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rat_renamer.sv
module rat_renamer
  import rat_pkg::*;
#(
  parameter int unsigned N_REG = NUM_LREG,
  parameter int unsigned N_GRP = GRP_W,
  parameter int unsigned N_RET = RET_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_GRP-1:0]         uop_vld_i,
  input  logic [N_GRP*LREG_W-1:0]  src_a_i,
  input  logic [N_GRP*LREG_W-1:0]  src_b_i,
  input  logic [N_GRP*LREG_W-1:0]  dst_i,
  input  logic [N_GRP*TAG_W-1:0]   dst_tag_i,
  input  logic [N_RET-1:0]         ret_vld_i,
  input  logic [N_RET*TAG_W-1:0]   ret_tag_i,
  input  logic                     flush_i,
  output logic [N_GRP*TAG_W-1:0]   src_a_tag_o,
  output logic [N_GRP-1:0]         src_a_rrf_o,
  output logic [N_GRP*TAG_W-1:0]   src_b_tag_o,
  output logic [N_GRP-1:0]         src_b_rrf_o
);
  logic [N_REG*TAG_W-1:0] map_tag;
  logic [N_REG-1:0]       map_rrf;

  rat_table #(.N_REG(N_REG), .N_GRP(N_GRP), .N_RET(N_RET)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_vld_i  (uop_vld_i),
    .wr_reg_i  (dst_i),
    .wr_tag_i  (dst_tag_i),
    .ret_vld_i (ret_vld_i),
    .ret_tag_i (ret_tag_i),
    .flush_i   (flush_i),
    .map_tag_o (map_tag),
    .map_rrf_o (map_rrf)
  );

  for (genvar s = 0; s < N_GRP; s++) begin : g_slot
    rat_src_lookup #(.N_REG(N_REG), .N_GRP(N_GRP), .SLOT(s)) u_src_a (
      .src_i     (src_a_i[s*LREG_W +: LREG_W]),
      .map_tag_i (map_tag),
      .map_rrf_i (map_rrf),
      .grp_vld_i (uop_vld_i),
      .grp_dst_i (dst_i),
      .grp_tag_i (dst_tag_i),
      .tag_o     (src_a_tag_o[s*TAG_W +: TAG_W]),
      .rrf_o     (src_a_rrf_o[s])
    );
    rat_src_lookup #(.N_REG(N_REG), .N_GRP(N_GRP), .SLOT(s)) u_src_b (
      .src_i     (src_b_i[s*LREG_W +: LREG_W]),
      .map_tag_i (map_tag),
      .map_rrf_i (map_rrf),
      .grp_vld_i (uop_vld_i),
      .grp_dst_i (dst_i),
      .grp_tag_i (dst_tag_i),
      .tag_o     (src_b_tag_o[s*TAG_W +: TAG_W]),
      .rrf_o     (src_b_rrf_o[s])
    );
  end
endmodule

// File: rtl/rat_renamer_chk.sv
module rat_renamer_chk
  import rat_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [GRP_W-1:0]         uop_vld_i,
  input logic [GRP_W*LREG_W-1:0]  src_a_i,
  input logic [GRP_W*LREG_W-1:0]  dst_i,
  input logic [GRP_W*TAG_W-1:0]   dst_tag_i,
  input logic [RET_W-1:0]         ret_vld_i,
  input logic                     flush_i,
  input logic [GRP_W*TAG_W-1:0]   src_a_tag_o,
  input logic [GRP_W-1:0]         src_a_rrf_o,
  input logic [NUM_LREG*TAG_W-1:0] map_tag_i,
  input logic [NUM_LREG-1:0]      map_rrf_i
);
  localparam int unsigned YS = GRP_W - 1;

  p_reset_state_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (&map_rrf_i && map_tag_i == '0));

  p_override_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_vld_i[0] && uop_vld_i[1] && src_a_i[LREG_W +: LREG_W] == dst_i[0 +: LREG_W])
    |-> (src_a_tag_o[TAG_W +: TAG_W] == dst_tag_i[0 +: TAG_W] && !src_a_rrf_o[1]));

  p_youngest_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && uop_vld_i[YS])
    |=> (map_tag_i[int'($past(dst_i[YS*LREG_W +: LREG_W]))*TAG_W +: TAG_W]
           == $past(dst_tag_i[YS*TAG_W +: TAG_W])
         && !map_rrf_i[$past(dst_i[YS*LREG_W +: LREG_W])]));

  p_flush_revert_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (&map_rrf_i && $stable(map_tag_i)));

  for (genvar r = 0; r < NUM_LREG; r++) begin : g_reg
    p_commit_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(map_rrf_i[r]) |-> ($past(flush_i) || $past(|ret_vld_i)));
  end
endmodule

bind rat_renamer rat_renamer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .uop_vld_i   (uop_vld_i),
  .src_a_i     (src_a_i),
  .dst_i       (dst_i),
  .dst_tag_i   (dst_tag_i),
  .ret_vld_i   (ret_vld_i),
  .flush_i     (flush_i),
  .src_a_tag_o (src_a_tag_o),
  .src_a_rrf_o (src_a_rrf_o),
  .map_tag_i   (map_tag),
  .map_rrf_i   (map_rrf)
);

// File: tb/sim_rat_renamer.sv
module sim_rat_renamer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  vld = '0;
  logic [8:0]  sa = '0, sb = '0, dst = '0;
  logic [17:0] dtag = '0;
  logic [2:0]  rv = '0;
  logic [17:0] rt = '0;
  logic        flush = 1'b0;
  logic [17:0] a_tag, b_tag;
  logic [2:0]  a_rrf, b_rrf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [5:0] m_tag [8];
  logic       m_rrf [8];

  always #2 clk = ~clk;

  rat_renamer u0 (
    .clk_i(clk), .rst_ni(rst_n), .uop_vld_i(vld), .src_a_i(sa), .src_b_i(sb),
    .dst_i(dst), .dst_tag_i(dtag), .ret_vld_i(rv), .ret_tag_i(rt), .flush_i(flush),
    .src_a_tag_o(a_tag), .src_a_rrf_o(a_rrf), .src_b_tag_o(b_tag), .src_b_rrf_o(b_rrf)
  );

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0d/%0b exp=%0d/%0b", req, act[6:1], act[0], exp[6:1], exp[0]);
    end
  endtask

  // expected {tag,rrf} for a source of slot s; returns override flag in bit 7
  function automatic logic [7:0] exp_src(int s, logic [2:0] r);
    logic [7:0] e;
    e = {1'b0, m_tag[r], m_rrf[r]};
    for (int j = 0; j < s; j++)
      if (vld[j] && dst[j*3 +: 3] == r) e = {1'b1, dtag[j*6 +: 6], 1'b0};
    return e;
  endfunction

  task automatic clr();
    vld = '0; rv = '0; flush = 1'b0;
  endtask

  task automatic slot(int s, logic [2:0] a, logic [2:0] b, logic [2:0] d, logic [5:0] t);
    vld[s] = 1'b1; sa[s*3 +: 3] = a; sb[s*3 +: 3] = b; dst[s*3 +: 3] = d; dtag[s*6 +: 6] = t;
  endtask

  // check outputs now, clock, then update the model
  task automatic cycle();
    logic [7:0] e;
    logic [5:0] nt [8];
    logic       nr [8];
    #1;
    for (int s = 0; s < 3; s++) begin
      if (vld[s]) begin
        e = exp_src(s, sa[s*3 +: 3]);
        chk(e[7] ? "R3 src_a" : "R2 src_a", {a_tag[s*6 +: 6], a_rrf[s]}, e[6:0]);
        e = exp_src(s, sb[s*3 +: 3]);
        chk(e[7] ? "R3 src_b" : "R2 src_b", {b_tag[s*6 +: 6], b_rrf[s]}, e[6:0]);
      end
    end
    @(posedge clk);
    for (int r = 0; r < 8; r++) begin
      bit w, h;
      nt[r] = m_tag[r]; nr[r] = m_rrf[r];
      w = 0; h = 0;
      for (int s = 0; s < 3; s++)
        if (vld[s] && dst[s*3 +: 3] == 3'(r)) begin w = 1; nt[r] = dtag[s*6 +: 6]; end
      for (int k = 0; k < 3; k++)
        if (rv[k] && rt[k*6 +: 6] == m_tag[r]) h = 1;
      if (flush) begin nt[r] = m_tag[r]; nr[r] = 1'b1; end
      else if (w) nr[r] = 1'b0;
      else if (h) nr[r] = 1'b1;
    end
    for (int r = 0; r < 8; r++) begin m_tag[r] = nt[r]; m_rrf[r] = nr[r]; end
    @(negedge clk);
  endtask

  // read register r through slot 0; slot 0 writes scratch r7
  task automatic peek(string req, logic [2:0] r, logic [5:0] et, logic er);
    clr(); slot(0, r, r, 3'd7, 6'd39);
    #1;
    chk(req, {a_tag[5:0], a_rrf[0]}, {et, er});
    cycle();
  endtask

  function automatic void summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < 8; r++) begin m_tag[r] = '0; m_rrf[r] = 1'b1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    clr(); slot(0, 3'd3, 3'd5, 3'd7, 6'd1);
    #1;
    chk("R1 reset a", {a_tag[5:0], a_rrf[0]}, {6'd0, 1'b1});
    chk("R1 reset b", {b_tag[5:0], b_rrf[0]}, {6'd0, 1'b1});
    cycle();

    // R5/R4: two writers of r2, invalid third slot
    clr(); slot(0, 0, 0, 3'd2, 6'd10); slot(1, 0, 0, 3'd2, 6'd11); slot(2, 0, 0, 3'd2, 6'd12);
    vld[2] = 1'b0;
    cycle();
    peek("R5 youngest write / R4 invalid no update", 3'd2, 6'd11, 1'b0);

    // R3: chain of writers to r4
    clr(); slot(0, 0, 0, 3'd4, 6'd20); slot(1, 3'd4, 0, 3'd4, 6'd21); slot(2, 3'd4, 3'd4, 3'd1, 6'd22);
    #1;
    chk("R3 slot1 sees slot0", {a_tag[11:6], a_rrf[1]}, {6'd20, 1'b0});
    chk("R3 slot2 nearest older", {b_tag[17:12], b_rrf[2]}, {6'd21, 1'b0});
    cycle();

    // R4: invalid older slot gives no override
    clr(); slot(0, 0, 0, 3'd6, 6'd30); slot(1, 3'd6, 3'd6, 3'd0, 6'd31); vld[0] = 1'b0;
    #1;
    chk("R4 invalid no override", {a_tag[11:6], a_rrf[1]}, {6'd0, 1'b1});
    cycle();

    // R6: retire current tag of r2, stale tag of r4
    clr(); rv = 3'b011; rt = {6'd0, 6'd20, 6'd11};
    cycle();
    peek("R6 retire commits", 3'd2, 6'd11, 1'b1);
    peek("R6 stale retire ignored", 3'd4, 6'd21, 1'b0);

    // R7: rename beats retire on r4
    clr(); rv = 3'b100; rt = {6'd21, 12'd0}; slot(1, 0, 0, 3'd4, 6'd23);
    cycle();
    peek("R7 rename over retire", 3'd4, 6'd23, 1'b0);

    // R8: flush discards rename, keeps tags
    clr(); flush = 1'b1; slot(0, 0, 0, 3'd5, 6'd33); slot(2, 3'd4, 0, 3'd4, 6'd34);
    cycle();
    peek("R8 flush keeps tag r4", 3'd4, 6'd23, 1'b1);
    peek("R8 flush discards rename r5", 3'd5, 6'd0, 1'b1);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      clr();
      for (int s = 0; s < 3; s++) begin
        if ($urandom_range(0, 3) != 0)
          slot(s, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
               3'($urandom_range(0, 7)), 6'($urandom_range(0, 39)));
      end
      if ($urandom_range(0, 7) == 0) begin
        slot(0, 0, 0, 3'd3, 6'($urandom_range(0, 39)));
        slot(1, 3'd3, 0, 3'd3, 6'($urandom_range(0, 39)));
        slot(2, 3'd3, 3'd3, 3'd3, 6'($urandom_range(0, 39)));
      end
      for (int k = 0; k < 3; k++) begin
        rv[k] = ($urandom_range(0, 1) == 1);
        rt[k*6 +: 6] = ($urandom_range(0, 1) == 1) ? m_tag[$urandom_range(0, 7)]
                                                    : 6'($urandom_range(0, 39));
      end
      flush = ($urandom_range(0, 31) == 0);
      cycle();
    end

    summary();
    $finish;
  end
endmodule